// File: doc/BRIEF.md
# Interleaved-Lane Dual-Rail Bit Serializer

This block turns a parallel word into a bit stream on a two-wire level-encoded dual-rail link. One wire, the value wire, always shows the bit currently on the link. The other, the toggle wire, is driven so that exactly one of the two wires changes for every bit sent. Because of this, a receiver can take each bit on any wire edge, even when the same value repeats, without a shared clock.

The accepted word is not held in one long shift register. It is spread across `LANES` short sub-registers: bit i goes to lane i mod `LANES`. Each lane shifts only once every `LANES` bit times. A one-hot round-robin pointer then picks lanes 0, 1, 2, … in turn, so only that final pick and the output encoder work at the full bit rate. Bits go out LSB first, one per clock.

Flow control is per word. The block raises `in_ready` when it is idle and takes a word with a valid/ready handshake. It sends all `WIDTH` bits. It then holds the link still and keeps `in_ready` low until the far end pulses `word_ack` once for the whole word.

Top module: `ledr_lane_serializer`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `link_value` and `link_toggle` are 0 and `in_ready` is 1.
- R2: A word taken on clock edge E0 (`in_valid` and `in_ready` both high) sends bit k of `in_word` on `link_value` from edge E0+k+1 onward, for k = 0 … WIDTH-1, LSB first.
- R3: Every transmitted bit changes exactly one of `link_value` and `link_toggle`. A bit equal to the previous one flips `link_toggle`, and a bit that differs leaves `link_toggle` unchanged.
- R4: When no bit is being sent (idle, or waiting for the acknowledge), neither link wire changes.
- R5: `in_ready` goes low on the edge that takes a word. It stays low until a `word_ack` pulse arrives after the last bit has gone out, and it is high on the edge that follows that pulse.
- R6: Bit i of the word is stored in lane i mod LANES. The lanes are read in round-robin order starting at lane 0, and each lane shifts at most once per cycle and only on its turn.
- R7: An `in_valid` with its `in_word` presented while `in_ready` is low is ignored. The next word sent is the one offered after `in_ready` returns high.
- R8: A `word_ack` pulse that arrives while bits are still being sent, or while idle, is ignored. The block still waits for a later `word_ack` before raising `in_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one output bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A word is offered on in_word |
| in_ready | output | 1 | Block can take a word this cycle |
| in_word | input | WIDTH | Parallel word to send, bit 0 sent first |
| word_ack | input | 1 | One-cycle acknowledge from the receiver for a whole word |
| link_value | output | 1 | Value wire: the bit currently on the link |
| link_toggle | output | 1 | Toggle wire: flips when a bit repeats the previous value |

## Verification
The bench uses the default WIDTH=16 and LANES=4. With these values every lane holds four bits, and the pointer wraps four times per word. Each lane position and each wrap of the round-robin pick therefore appears in the expected bit order. Directed words test the R3 rule at its two extremes: all zeros and all ones (every bit repeats), and alternating bits (every bit changes). Single-bit words at bit 0 and bit 15 check the first and last lane slots. Random words cover mixed runs. Acknowledges sent mid-word and junk offers made while `in_ready` is low test the per-word handshake.

// File: rtl/ledr_ser_pkg.sv
package ledr_ser_pkg;

  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_SEND = 2'd1,
    TX_WAIT = 2'd2
  } tx_state_e;

endpackage

// File: rtl/ledr_subshift.sv
module ledr_subshift #(
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DEPTH-1:0] load_bits,
  input  logic             shift,
  output logic             head
);

  logic [DEPTH-1:0] data_q;
  logic [DEPTH-1:0] data_d;

  always_comb begin
    data_d = data_q;
    if (load) begin
      data_d = load_bits;
    end else if (shift) begin
      data_d = {1'b0, data_q[DEPTH-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (load || shift) begin
      data_q <= data_d;
    end
  end

  assign head = data_q[0];

  // R6
  lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !shift) |=> $stable(data_q));

endmodule

// File: rtl/ledr_rr_select.sv
module ledr_rr_select #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             advance,
  output logic [LANES-1:0] sel
);

  localparam logic [LANES-1:0] FIRST = LANES'(1);

  logic [LANES-1:0] sel_q;
  logic [LANES-1:0] sel_d;

  generate
    if (LANES == 1) begin : g_single
      always_comb sel_d = FIRST;
    end else begin : g_multi
      always_comb begin
        sel_d = sel_q;
        if (clear) begin
          sel_d = FIRST;
        end else if (advance) begin
          sel_d = {sel_q[LANES-2:0], sel_q[LANES-1]};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= FIRST;
    end else if (clear || advance) begin
      sel_q <= sel_d;
    end
  end

  assign sel = sel_q;

  // R6
  pick_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sel_q) == 1);

endmodule

// File: rtl/ledr_tx_stage.sv
module ledr_tx_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic emit,
  input  logic bit_in,
  output logic value_q,
  output logic toggle_q
);

  logic value_d;
  logic toggle_d;

  always_comb begin
    value_d  = value_q;
    toggle_d = toggle_q;
    if (emit) begin
      value_d  = bit_in;
      toggle_d = (bit_in == value_q) ? ~toggle_q : toggle_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value_q  <= 1'b0;
      toggle_q <= 1'b0;
    end else if (emit) begin
      value_q  <= value_d;
      toggle_q <= toggle_d;
    end
  end

  // R3
  one_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    emit |=> ($countones({value_q, toggle_q} ^ {$past(value_q), $past(toggle_q)}) == 1));

  // R4
  quiet_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !emit |=> ($stable(value_q) && $stable(toggle_q)));

endmodule

// File: rtl/ledr_lane_serializer.sv
module ledr_lane_serializer
  import ledr_ser_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_word,
  input  logic             word_ack,
  output logic             link_value,
  output logic             link_toggle
);

  localparam int DEPTH = WIDTH / LANES;
  localparam int CW    = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST_BIT = CW'(WIDTH - 1);

  tx_state_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;

  logic                         take;
  logic                         emit;
  logic [LANES-1:0]             sel;
  logic [LANES-1:0]             heads;
  logic [LANES-1:0]             lane_shift;
  logic [LANES-1:0][DEPTH-1:0]  lane_bits;
  logic                         cur_bit;

  assign take     = in_valid && (st_q == TX_IDLE);
  assign emit     = (st_q == TX_SEND);
  assign in_ready = (st_q == TX_IDLE);

  // Next-state logic
  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      TX_IDLE: begin
        if (in_valid) begin
          st_d  = TX_SEND;
          cnt_d = '0;
        end
      end
      TX_SEND: begin
        cnt_d = cnt_q + CW'(1);
        if (cnt_q == LAST_BIT) begin
          st_d  = TX_WAIT;
          cnt_d = '0;
        end
      end
      TX_WAIT: begin
        if (word_ack) st_d = TX_IDLE;
      end
      default: st_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= TX_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  // Lane split: bit i goes to lane i mod LANES, slot i / LANES
  generate
    for (genvar j = 0; j < LANES; j++) begin : g_lane
      for (genvar d = 0; d < DEPTH; d++) begin : g_slot
        assign lane_bits[j][d] = in_word[d*LANES + j];
      end
      assign lane_shift[j] = emit && sel[j];

      ledr_subshift #(.DEPTH(DEPTH)) i_lane (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (take),
        .load_bits (lane_bits[j]),
        .shift     (lane_shift[j]),
        .head      (heads[j])
      );
    end
  endgenerate

  ledr_rr_select #(.LANES(LANES)) i_pick (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (take),
    .advance (emit),
    .sel     (sel)
  );

  assign cur_bit = |(heads & sel);

  ledr_tx_stage i_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .emit     (emit),
    .bit_in   (cur_bit),
    .value_q  (link_value),
    .toggle_q (link_toggle)
  );

  // R5
  take_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !in_ready);

  // R5
  wait_holds_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TX_WAIT && !word_ack) |=> !in_ready);

  // R8
  early_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TX_SEND && cnt_q != LAST_BIT) |=> !in_ready);

  // R6
  one_lane_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lane_shift) <= 1);

endmodule

// File: tb/test_ledr_lane_serializer.sv
module test_ledr_lane_serializer;

  localparam int WIDTH = 16;
  localparam int LANES = 4;

  logic             clk;
  logic             rst_n;
  logic             in_valid;
  logic             in_ready;
  logic [WIDTH-1:0] in_word;
  logic             word_ack;
  logic             link_value;
  logic             link_toggle;

  int checks;
  int failures;
  int cycles;
  logic prev_v;
  logic prev_t;

  ledr_lane_serializer #(.WIDTH(WIDTH), .LANES(LANES)) i_ledr_lane_serializer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .word_ack(word_ack),
    .link_value(link_value), .link_toggle(link_toggle)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic exp_toggle(logic b, logic pv, logic pt);
    return (b == pv) ? ~pt : pt;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      finish_run();
    end
  end

  task automatic send_word(logic [WIDTH-1:0] w, bit early_ack, bit junk);
    @(negedge clk);
    check("R5 ready before offer", in_ready, 1);
    in_valid = 1'b1;
    in_word  = w;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    in_word  = ~w;
    check("R5 ready low after take", in_ready, 0);
    for (int k = 0; k < WIDTH; k++) begin
      word_ack = early_ack && (k == 3);
      @(posedge clk);
      @(negedge clk);
      word_ack = 1'b0;
      // R2 / R6 lane order, R3 single edge per bit
      check("R2 bit value", link_value, w[k]);
      check("R3 toggle wire", link_toggle, exp_toggle(w[k], prev_v, prev_t));
      prev_v = w[k];
      prev_t = exp_toggle(w[k], prev_v ^ 1'b0, prev_t) ^ 1'b0;
      prev_t = link_toggle;
    end
    check("R8 ready still low after send", in_ready, 0);
    for (int c = 0; c < 3; c++) begin
      if (junk) begin
        in_valid = 1'b1;
        in_word  = WIDTH'($urandom);
      end
      @(posedge clk);
      @(negedge clk);
      check("R4 link quiet while waiting", {link_value, link_toggle}, {prev_v, prev_t});
      check("R5 ready low while waiting", in_ready, 0);
    end
    in_valid = 1'b0;
    word_ack = 1'b1;
    @(posedge clk);
    @(negedge clk);
    word_ack = 1'b0;
    check("R5 ready after ack", in_ready, 1);
    check("R4 link quiet at ack", {link_value, link_toggle}, {prev_v, prev_t});
  endtask

  initial begin
    checks   = 0;
    failures = 0;
    cycles   = 0;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_word  = '0;
    word_ack = 1'b0;
    void'($urandom(32'h5eed_0017));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset wires", {link_value, link_toggle}, 2'b00);
    check("R1 reset ready", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 wires after release", {link_value, link_toggle}, 2'b00);
    check("R1 ready after release", in_ready, 1);
    prev_v = 1'b0;
    prev_t = 1'b0;

    // R8 ack while idle is ignored
    word_ack = 1'b1;
    @(posedge clk);
    @(negedge clk);
    word_ack = 1'b0;
    check("R8 idle ack no effect", {in_ready, link_value, link_toggle}, 3'b100);
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R4 idle quiet", {link_value, link_toggle}, 2'b00);

    send_word(16'h0000, 1'b0, 1'b0);
    send_word(16'hFFFF, 1'b1, 1'b0);
    send_word(16'hAAAA, 1'b0, 1'b1);  // R7 junk offers while busy
    send_word(16'h5555, 1'b1, 1'b1);
    send_word(16'h0001, 1'b0, 1'b0);  // R6 lane 0 slot 0
    send_word(16'h8000, 1'b0, 1'b1);  // R6 lane 3 last slot
    send_word(16'h1248, 1'b0, 1'b0);  // R6 one bit per lane
    for (int n = 0; n < 20; n++) begin
      send_word(WIDTH'($urandom), n[0], n[1]);
    end
    finish_run();
  end

endmodule